// File: doc/BRIEF.md
# Execute-Stage Integer ALU with Byte Swaps

This block is the arithmetic unit of the execute stage of a 64-bit register machine. Each operation arrives as an 8-bit opcode with the current destination register value, the source register value and a 32-bit signed immediate. The block returns the 64-bit value to write back to the destination register. The low three opcode bits pick 32-bit or 64-bit mode. Bit 3 picks whether the second operand is the source register or the immediate. The high nibble names the operation. All arithmetic wraps silently. Division and modulo by zero produce defined results and never trap.

Most operations finish in one cycle. Unsigned divide and modulo use a restoring divider that produces one quotient bit per cycle, so the input side has a ready signal that drops while the divider is busy. Each result appears as a one-cycle `out_valid` pulse. An operation that cannot be decoded still produces that pulse, but with `out_illegal` set and a zero result, and the result must not be written back.

Top module: `alu_exec`

## Requirements
- R1: The opcode is decoded as follows. Bits [2:0] equal to 4 select 32-bit mode and equal to 7 select 64-bit mode; any other value there is illegal. Bit 3 = 1 takes the source register as the second operand; bit 3 = 0 takes the immediate, sign-extended to 64 bits. Bits [7:4] hold the operation code.
- R2: Operation codes 0x0 add, 0x1 subtract and 0x2 multiply give the low bits of the wrapped result. For example, 64-bit add of all-ones and 1 gives 0.
- R3: In 32-bit mode both operands are taken as their low 32 bits, and every result except the byte swap has bits [63:32] cleared.
- R4: Code 0x4 is OR, 0x5 is AND, 0xA is XOR and 0xB is move (the result is the second operand). Code 0x8 negates the destination in two's complement (0 minus destination).
- R5: Code 0x6 is a left shift, 0x7 a logical right shift and 0xC an arithmetic right shift, which copies bit 63 (or bit 31 in 32-bit mode). The shift amount is the second operand masked with 0x3F in 64-bit mode and with 0x1F in 32-bit mode.
- R6: Code 0x3 is unsigned divide (quotient) and 0x9 is unsigned modulo (remainder). In 32-bit mode the immediate is effectively zero-extended. In 64-bit mode it is sign-extended and then treated as unsigned. With a nonzero divisor, `out_valid` rises 32 (32-bit mode) or 64 (64-bit mode) cycles after the cycle that accepts the operation, and `in_ready` stays low for those cycles.
- R7: A divide by zero gives 0. A modulo by zero gives the destination unchanged in 64-bit mode, or the destination with its upper 32 bits cleared in 32-bit mode. Both finish in one cycle.
- R8: Code 0xD is a byte swap, legal only with bits [2:0] = 4, and it uses only the destination. The immediate selects a width of 16, 32 or 64. Bit 3 = 0 targets little-endian order and bit 3 = 1 targets big-endian order. The host order is little-endian by default. A little-endian target keeps the low width bits and zero-extends them. A big-endian target reverses the bytes within the width and clears the bits above it.
- R9: The following are illegal: operation codes 0xE and 0xF, any other swap width, a swap in 64-bit mode, and an unknown class. Each still gives a one-cycle `out_valid` with `out_illegal` = 1 and `out_result` = 0.
- R10: After reset `in_ready` = 1 and `out_valid` = 0. An operation other than a divide or modulo with a nonzero divisor raises `out_valid` for exactly one cycle, in the cycle after it is accepted, and `in_ready` stays high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can accept an operation |
| op | input | 8 | Opcode: class, source select, operation |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Signed immediate |
| out_valid | output | 1 | One-cycle result strobe |
| out_illegal | output | 1 | Operation not decodable; result must not be written |
| out_result | output | 64 | Write-back value |

## Verification
The hardest cases to reach are the divider's corners. A 64-bit divide by a negative immediate becomes a division by a huge unsigned value, and a 32-bit divide by 0xFFFFFFFF must see that immediate zero-extended. Both are driven directly, alongside zero divisors in each mode, where the one-cycle path must take over from the multi-cycle one. A run of pseudo-random operations mixes slow and fast operations back to back, so the ready signal is observed as it falls and rises around each divider session.

// File: rtl/alu_exec.sv
module alu_exec #(
  parameter bit HOST_LE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  op,
  input  logic [63:0] dst_val,
  input  logic [63:0] src_val,
  input  logic [31:0] imm,
  output logic        out_valid,
  output logic        out_illegal,
  output logic [63:0] out_result
);
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);

  logic [2:0] cls;
  logic [3:0] code;
  logic       wide, legal_cls;
  assign cls       = op[2:0];
  assign code      = op[7:4];
  assign wide      = (cls == 3'd7);
  assign legal_cls = (cls == 3'd7) || (cls == 3'd4);

  logic [XLEN-1:0] b_full, a, b;
  assign b_full = op[3] ? src_val : {{HALF{imm[31]}}, imm};
  assign a      = wide ? dst_val : {{HALF{1'b0}}, dst_val[HALF-1:0]};
  assign b      = wide ? b_full  : {{HALF{1'b0}}, b_full[HALF-1:0]};

  logic [5:0] shamt;
  assign shamt = wide ? b[5:0] : {1'b0, b[4:0]};

  logic [HALF-1:0] ar_half;
  logic [XLEN-1:0] ar_full;
  assign ar_half = $signed(dst_val[HALF-1:0]) >>> shamt[4:0];
  assign ar_full = $signed(dst_val) >>> shamt;

  logic swap_ok, to_big;
  logic [XLEN-1:0] swap_res;
  assign swap_ok = !wide && (imm == 32'd16 || imm == 32'd32 || imm == 32'd64);
  assign to_big  = (op[3] == HOST_LE);

  always_comb begin
    int nbytes;
    nbytes   = (imm == 32'd16) ? 2 : (imm == 32'd32) ? 4 : 8;
    swap_res = '0;
    for (int i = 0; i < XLEN / 8; i++)
      if (i < nbytes)
        swap_res[8*i +: 8] = to_big ? dst_val[8*(nbytes-1-i) +: 8] : dst_val[8*i +: 8];
  end

  logic            ill;
  logic [XLEN-1:0] r;
  always_comb begin
    ill = 1'b0;
    r   = '0;
    case (code)
      4'h0: r = a + b;
      4'h1: r = a - b;
      4'h2: r = a * b;
      4'h3: r = '0;
      4'h4: r = a | b;
      4'h5: r = a & b;
      4'h6: r = a << shamt;
      4'h7: r = a >> shamt;
      4'h8: r = '0 - a;
      4'h9: r = a;
      4'hA: r = a ^ b;
      4'hB: r = b;
      4'hC: r = wide ? ar_full : {{HALF{1'b0}}, ar_half};
      4'hD: if (swap_ok) r = swap_res; else ill = 1'b1;
      default: ill = 1'b1;
    endcase
    if (!legal_cls) ill = 1'b1;
    if (!wide && code != 4'hD) r[XLEN-1:HALF] = '0;
  end

  logic            busy, is_mod;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] qr, rr, dv;
  logic [XLEN:0]   trial, diff;
  logic            ge;
  logic [XLEN-1:0] nr, nq;
  logic            start_div;

  assign in_ready  = !busy;
  assign start_div = in_valid && !busy && !ill && (code == 4'h3 || code == 4'h9) && (b != '0);
  assign trial     = {rr, qr[XLEN-1]};
  assign diff      = trial - {1'b0, dv};
  assign ge        = !diff[XLEN];
  assign nr        = ge ? diff[XLEN-1:0] : trial[XLEN-1:0];
  assign nq        = {qr[XLEN-2:0], ge};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      is_mod      <= 1'b0;
      cnt         <= '0;
      qr          <= '0;
      rr          <= '0;
      dv          <= '0;
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      if (busy) begin
        rr  <= nr;
        qr  <= nq;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy       <= 1'b0;
          out_valid  <= 1'b1;
          out_result <= is_mod ? nr : nq;
        end
      end else if (in_valid) begin
        if (start_div) begin
          busy   <= 1'b1;
          cnt    <= wide ? CW'(XLEN) : CW'(HALF);
          qr     <= wide ? a : {a[HALF-1:0], {HALF{1'b0}}};
          rr     <= '0;
          dv     <= b;
          is_mod <= (code == 4'h9);
        end else begin
          out_valid   <= 1'b1;
          out_illegal <= ill;
          out_result  <= ill ? '0 : r;
        end
      end
    end
  end
endmodule

module alu_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  op,
  input logic        out_valid,
  input logic        out_illegal,
  input logic [63:0] out_result
);
  logic narrow_q;
  always_ff @(posedge clk) begin
    if (!rst_n) narrow_q <= 1'b0;
    else if (in_valid && in_ready) narrow_q <= (op[2:0] == 3'd4) && (op[7:4] != 4'hD);
  end

  // R9
  illegal_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == 64'd0);

  // R9
  illegal_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_illegal);

  // R3
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal && narrow_q |-> out_result[63:32] == 32'd0);

  // R10
  single_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op[7:4] != 4'h3 && op[7:4] != 4'h9 |=> out_valid);

  // R6
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  // R10
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(in_valid && in_ready) |=> !out_valid);
endmodule

bind alu_exec alu_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
  .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
);

// File: tb/sim_alu_exec.sv
`timescale 1ns/1ps
module sim_alu_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  op = '0;
  logic [63:0] dst_val = '0, src_val = '0;
  logic [31:0] imm = '0;
  logic        out_valid, out_illegal;
  logic [63:0] out_result;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_exec u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .dst_val(dst_val), .src_val(src_val), .imm(imm), .out_valid(out_valid),
    .out_illegal(out_illegal), .out_result(out_result));

  function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [64:0] model(logic [7:0] o, logic [63:0] d, logic [63:0] s, logic [31:0] i);
    longint unsigned x, y, res;
    bit w64, bad;
    int sh, nb;
    bad = 0; res = 0;
    w64 = (o[2:0] == 3'd7);
    if (o[2:0] != 3'd4 && o[2:0] != 3'd7) bad = 1;
    x = w64 ? d : (d & 64'hFFFF_FFFF);
    y = o[3] ? s : {{32{i[31]}}, i};
    if (!w64) y = y & 64'hFFFF_FFFF;
    sh = w64 ? int'(y % 64) : int'(y % 32);
    case (o[7:4])
      4'h0: res = x + y;
      4'h1: res = x - y;
      4'h2: res = x * y;
      4'h3: res = (y == 0) ? 0 : x / y;
      4'h4: res = x | y;
      4'h5: res = x & y;
      4'h6: res = x << sh;
      4'h7: res = x >> sh;
      4'h8: res = 0 - x;
      4'h9: res = (y == 0) ? x : x % y;
      4'hA: res = x ^ y;
      4'hB: res = y;
      4'hC: if (w64) res = longint'(x) >>> sh;
            else res = longint'(int'(x[31:0])) >>> sh;
      4'hD: begin
        if (w64 || !(i == 16 || i == 32 || i == 64)) bad = 1;
        nb = i / 8;
        for (int k = 0; k < nb; k++)
          res[8*k +: 8] = o[3] ? d[8*(nb-1-k) +: 8] : d[8*k +: 8];
      end
      default: bad = 1;
    endcase
    if (!w64 && o[7:4] != 4'hD) res = res & 64'hFFFF_FFFF;
    if (bad) res = 0;
    return {bad, res};
  endfunction

  function automatic int latency(logic [7:0] o, logic [63:0] s, logic [31:0] i);
    logic [64:0] e;
    longint unsigned y;
    bit w64;
    e = model(o, 64'd0, s, i);
    w64 = (o[2:0] == 3'd7);
    y = o[3] ? s : {{32{i[31]}}, i};
    if (!w64) y = y & 64'hFFFF_FFFF;
    if (e[64] || !(o[7:4] == 4'h3 || o[7:4] == 4'h9) || y == 0) return 0;
    return w64 ? 64 : 32;
  endfunction

  task automatic run(input logic [7:0] o, input logic [63:0] d, input logic [63:0] s,
                     input logic [31:0] i, input string tag);
    logic [64:0] e;
    int lat;
    e = model(o, d, s, i);
    lat = latency(o, s, i);
    vectors++;
    @(negedge clk);
    chk(in_ready === 1'b1, {tag, " ready before"}, 64'(in_ready), 64'd1);
    op = o; dst_val = d; src_val = s; imm = i; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 0; c <= lat; c++) begin
      if (c > 0) @(negedge clk);
      chk(out_valid === (c == lat), {tag, " valid timing"}, 64'(out_valid), 64'(c == lat));
      chk(in_ready === (c == lat), {tag, " ready timing"}, 64'(in_ready), 64'(c == lat));
      if (c == lat) begin
        chk(out_illegal === e[64], {tag, " illegal"}, 64'(out_illegal), 64'(e[64]));
        chk(out_result === e[63:0], {tag, " result"}, out_result, e[63:0]);
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [63:0] lf;
    logic [7:0] rop;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    vectors++;
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R10 reset", {62'd0, in_ready, out_valid}, 64'd2);

    run(8'h07, 64'h0000_0001_0000_0000, 0, 32'h1122_3344, "R1 R2 add imm 64");
    run(8'h0F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, "R2 add wrap 64");
    run(8'h1F, 64'd0, 64'd1, 0, "R2 sub underflow 64");
    run(8'h2F, 64'h1_0000_0001, 64'h3_0000_0005, 0, "R2 mul 64");
    run(8'h0C, 64'hABCD_0000_FFFF_FFFF, 64'h1234_0000_0000_0002, 0, "R3 add 32 wrap");
    run(8'h24, 64'hFFFF_FFFF_8000_0000, 0, 32'd3, "R3 mul 32");
    run(8'hB7, 64'd5, 0, 32'hFFFF_FFF0, "R1 mov imm sign ext 64");
    run(8'hBF, 64'd5, 64'hDEAD_BEEF_0123_4567, 32'hFFFF_FFF0, "R1 mov reg 64");
    run(8'hB4, 64'd5, 0, 32'hFFFF_FFF0, "R3 mov imm 32");
    run(8'h4F, 64'hF0F0_0000_0000_000F, 64'h0F00_0000_0000_00F0, 0, "R4 or");
    run(8'h57, 64'hFFFF_FFFF_FFFF_FF0F, 0, 32'h8000_00FF, "R4 and imm");
    run(8'hAC, 64'h1111_2222_3333_4444, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R4 xor 32");
    run(8'h87, 64'd1, 0, 0, "R4 neg 64");
    run(8'h84, 64'h7777_0000_0000_0001, 0, 0, "R4 neg 32");
    run(8'h67, 64'd1, 0, 32'd65, "R5 lsh mask 64");
    run(8'h64, 64'd1, 0, 32'd33, "R5 lsh mask 32");
    run(8'h77, 64'h8000_0000_0000_0000, 0, 32'd63, "R5 rsh 64");
    run(8'hC7, 64'h8000_0000_0000_0000, 0, 32'd4, "R5 arsh 64");
    run(8'hCC, 64'h0000_0000_8000_0000, 64'd36, 0, "R5 arsh 32");
    run(8'h3F, 64'd1000000007, 64'd13, 0, "R6 div 64");
    run(8'h37, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'hFFFF_FFFE, "R6 div 64 neg imm");
    run(8'h34, 64'h5_FFFF_FFFF, 0, 32'hFFFF_FFFF, "R6 div 32 imm zero ext");
    run(8'h9F, 64'hFEDC_BA98_7654_3210, 64'd1000, 0, "R6 mod 64");
    run(8'h94, 64'hFFFF_0000_0000_0064, 0, 32'd7, "R6 mod 32");
    run(8'h3F, 64'd77, 64'd0, 0, "R7 div zero 64");
    run(8'h34, 64'd77, 64'h1_0000_0000, 0, "R7 div zero 32");
    run(8'h9F, 64'hAAAA_5555_1234_5678, 64'd0, 0, "R7 mod zero 64");
    run(8'h97, 64'hAAAA_5555_1234_5678, 0, 0, "R7 mod zero 64 imm");
    run(8'h94, 64'hAAAA_5555_1234_5678, 0, 0, "R7 mod zero 32");
    run(8'hD4, 64'h0102_0304_0506_0708, 0, 32'd16, "R8 le16");
    run(8'hD4, 64'h0102_0304_0506_0708, 0, 32'd32, "R8 le32");
    run(8'hD4, 64'h0102_0304_0506_0708, 0, 32'd64, "R8 le64");
    run(8'hDC, 64'h0102_0304_0506_0708, 0, 32'd16, "R8 be16");
    run(8'hDC, 64'h0102_0304_0506_0708, 0, 32'd32, "R8 be32");
    run(8'hDC, 64'h0102_0304_0506_0708, 0, 32'd64, "R8 be64");
    run(8'hDC, 64'h0102_0304_0506_0708, 0, 32'd8, "R9 swap width");
    run(8'hD7, 64'h0102_0304_0506_0708, 0, 32'd16, "R9 swap 64 class");
    run(8'hE7, 64'd9, 64'd9, 0, "R9 code E");
    run(8'hFC, 64'd9, 64'd9, 0, "R9 code F");
    run(8'h0D, 64'd9, 64'd9, 0, "R9 class 5");
    run(8'h00, 64'd9, 64'd9, 0, "R9 class 0");

    lf = 64'hACE1_2468_9BDF_1357;
    for (int n = 0; n < 60; n++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      rop = {lf[7:4] % 4'd14, lf[8], lf[9] ? 3'd7 : 3'd4};
      run(rop, {lf[31:0], lf[63:32]}, lf ^ 64'h5A5A_F00F_3C3C_0FF0, lf[40:9], "R2 R6 random mix");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule